// File: doc/BRIEF.md
# Latched Fault Status and Interrupt Controller

This block sits between a supply regulator's analog protection comparators and the register side of a two-wire serial slave. It takes the live comparator levels for over-current, over-temperature, input undervoltage and output-voltage-out-of-window, together with the commanded output enable, and produces three things: an 8-bit status byte for the serial slave to return, an active-low interrupt line that models an open-drain request pin, and the effective enable that actually turns the regulator on.

Over-current is filtered by a persistence timer running on the system clock, so brief current spikes do not trip it. Over-current, over-temperature and undervoltage are sticky: once set they stay set and hold the output off until a status read happens while the live condition is gone. The interrupt is raised on each new sticky fault and once when the block leaves reset, and it drops when the serial slave reports that it was addressed for a read. The disable and power-not-good bits follow live conditions and never raise the interrupt.

Top module: `lnb_fault_status`

## Requirements
- R1: The status byte places DIS at bit 0, OCP at bit 2, PNG at bit 4, TSD at bit 6 and UVLO at bit 7; bits 1, 3 and 5 always read 0.
- R2: OCP sets at the clock edge on which the over-current flag has been sampled high on PERSIST_CYC consecutive edges (PERSIST_CYC = CLK_FREQ_HZ/1e6 * PERSIST_US), and not one edge earlier.
- R3: A drop of the over-current flag before terminal count restarts the persistence count from zero.
- R4: OCP, TSD and UVLO are sticky: each clears only on a cycle with the status-captured strobe high and its live flag low; otherwise it holds 1.
- R5: A live over-temperature or undervoltage flag forces the effective enable low in the same cycle, and the matching sticky bit is set at the next edge.
- R6: DIS reads 1 exactly when the effective enable is low, whatever the reason.
- R7: PNG reads 1 while the effective enable is low or the voltage-window flag is high, with no latching.
- R8: The interrupt is low (asserted) on leaving reset and is driven low at the edge on which any sticky bit goes from 0 to 1; changes of DIS or PNG alone never assert it.
- R9: The read-address-matched strobe releases the interrupt (high) at the next edge, unless a new sticky fault sets on that same edge.
- R10: The effective enable equals the commanded enable AND no sticky fault AND no live over-temperature or undervoltage flag, so after an OCP shutdown the output returns only once a status read has cleared OCP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release marks valid supplies |
| ctrl_en_i | input | 1 | Commanded output enable from the control register |
| oc_flag_i | input | 1 | Live over-current comparator level |
| ot_flag_i | input | 1 | Live over-temperature comparator level |
| uv_flag_i | input | 1 | Live input-undervoltage comparator level |
| vwin_bad_i | input | 1 | Live output-voltage-outside-window level |
| rd_addr_hit_i | input | 1 | Strobe: serial slave addressed for a read |
| stat_cap_i | input | 1 | Strobe: status byte captured by the serial slave |
| status_o | output | 8 | Status byte |
| irq_no | output | 1 | Interrupt request, active low |
| out_en_o | output | 1 | Effective regulator enable |

## Verification
Directed sequences hold the over-current flag for exactly one edge short of and exactly at the persistence count, and break a long run with a single low cycle, which separates an off-by-one timer from one that fails to restart. Each sticky fault is read once while its flag is still live and once after it clears, telling a read-clearing latch from a level follower or a latch that ignores the live condition. A window-flag toggle and an enable toggle with no faults show that DIS and PNG move without touching the interrupt. Random runs with a fixed seed then mix all flags, strobes and the enable against a cycle model, covering coincident set-and-release and set-and-clear edges.

// File: rtl/lnb_fault_pkg.sv
package lnb_fault_pkg;
  localparam int STAT_W  = 8;
  localparam int BIT_DIS = 0;
  localparam int BIT_OCP = 2;
  localparam int BIT_PNG = 4;
  localparam int BIT_TSD = 6;
  localparam int BIT_UV  = 7;

  typedef enum logic [1:0] {
    F_OCP = 2'd0,
    F_TSD = 2'd1,
    F_UV  = 2'd2
  } fault_idx_e;

  localparam int NUM_FAULTS = 3;
endpackage

// File: rtl/oc_persist_timer.sv
module oc_persist_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  output logic trip_o
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!oc_i)       cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  // high on the edge completing LIMIT consecutive high samples
  assign trip_o = oc_i && (cnt_q == TERM);
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] live_i,
  input  logic         clr_req_i,
  output logic [N-1:0] q_o,
  output logic         new_o
);
  logic [N-1:0] q_q;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q_q[g] <= 1'b0;
      else if (set_i[g])                 q_q[g] <= 1'b1;
      else if (clr_req_i && !live_i[g])  q_q[g] <= 1'b0;
    end
    assign rise[g] = set_i[g] && !q_q[g];
  end

  assign q_o   = q_q;
  assign new_o = |rise;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic new_fault_i,
  input  logic release_i,
  output logic irq_no
);
  logic req_q;

  // request pending out of reset: supplies just became valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          req_q <= 1'b1;
    else if (new_fault_i) req_q <= 1'b1;
    else if (release_i)   req_q <= 1'b0;
  end

  assign irq_no = ~req_q;
endmodule

// File: rtl/lnb_fault_status.sv
module lnb_fault_status
  import lnb_fault_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int PERSIST_US  = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_en_i,
  input  logic              oc_flag_i,
  input  logic              ot_flag_i,
  input  logic              uv_flag_i,
  input  logic              vwin_bad_i,
  input  logic              rd_addr_hit_i,
  input  logic              stat_cap_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_no,
  output logic              out_en_o
);
  localparam int PERSIST_CYC = (CLK_FREQ_HZ / 1_000_000) * PERSIST_US;

  logic                  oc_trip;
  logic [NUM_FAULTS-1:0] f_set, f_live, f_q;
  logic                  f_new;

  oc_persist_timer #(.LIMIT(PERSIST_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .oc_i   (oc_flag_i),
    .trip_o (oc_trip)
  );

  always_comb begin
    f_set        = '0;
    f_live       = '0;
    f_set[F_OCP] = oc_trip;
    f_set[F_TSD] = ot_flag_i;
    f_set[F_UV]  = uv_flag_i;
    f_live[F_OCP] = oc_flag_i;
    f_live[F_TSD] = ot_flag_i;
    f_live[F_UV]  = uv_flag_i;
  end

  fault_latch_bank #(.N(NUM_FAULTS)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (f_set),
    .live_i    (f_live),
    .clr_req_i (stat_cap_i),
    .q_o       (f_q),
    .new_o     (f_new)
  );

  irq_ctrl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .new_fault_i (f_new),
    .release_i   (rd_addr_hit_i),
    .irq_no      (irq_no)
  );

  // live thermal/supply flags cut the output before the latch catches them
  assign out_en_o = ctrl_en_i && !(|f_q) && !ot_flag_i && !uv_flag_i;

  always_comb begin
    status_o          = '0;
    status_o[BIT_DIS] = !out_en_o;
    status_o[BIT_OCP] = f_q[F_OCP];
    status_o[BIT_PNG] = !out_en_o || vwin_bad_i;
    status_o[BIT_TSD] = f_q[F_TSD];
    status_o[BIT_UV]  = f_q[F_UV];
  end
endmodule

// File: rtl/lnb_fault_status_chk.sv
module lnb_fault_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_en_i,
  input logic       oc_flag_i,
  input logic       ot_flag_i,
  input logic       uv_flag_i,
  input logic       rd_addr_hit_i,
  input logic       stat_cap_i,
  input logic [7:0] status_o,
  input logic       irq_no,
  input logic       out_en_o
);
  // R4
  ocp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && !stat_cap_i) |=> status_o[2]);
  // R4
  tsd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] && (!stat_cap_i || ot_flag_i)) |=> status_o[6]);
  // R4
  uv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && (!stat_cap_i || uv_flag_i)) |=> status_o[7]);
  // R2
  ocp_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(oc_flag_i));
  // R5
  live_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_flag_i || uv_flag_i) |-> !out_en_o);
  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($rose(status_o[2]) || $rose(status_o[6]) || $rose(status_o[7])));
  // R9
  irq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_hit_i && !oc_flag_i && !ot_flag_i && !uv_flag_i) |=> irq_no);
  // R10
  en_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> ctrl_en_i);
endmodule

bind lnb_fault_status lnb_fault_status_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_en_i     (ctrl_en_i),
  .oc_flag_i     (oc_flag_i),
  .ot_flag_i     (ot_flag_i),
  .uv_flag_i     (uv_flag_i),
  .rd_addr_hit_i (rd_addr_hit_i),
  .stat_cap_i    (stat_cap_i),
  .status_o      (status_o),
  .irq_no        (irq_no),
  .out_en_o      (out_en_o)
);

// File: tb/lnb_fault_status_tb.sv
`timescale 1ns/1ps
module lnb_fault_status_tb;
  localparam int CLK_HZ = 4_000_000;
  localparam int P_US   = 5;
  localparam int LIM    = (CLK_HZ / 1_000_000) * P_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, oc = 0, ot = 0, uv = 0, vw = 0, rd = 0, cap = 0;
  logic [7:0] st;
  logic irq_n, oen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lnb_fault_status #(.CLK_FREQ_HZ(CLK_HZ), .PERSIST_US(P_US)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(en), .oc_flag_i(oc),
    .ot_flag_i(ot), .uv_flag_i(uv), .vwin_bad_i(vw),
    .rd_addr_hit_i(rd), .stat_cap_i(cap),
    .status_o(st), .irq_no(irq_n), .out_en_o(oen)
  );

  // cycle model built from the requirements
  int m_cnt;
  bit m_ocp, m_tsd, m_uv, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ocp <= 0; m_tsd <= 0; m_uv <= 0; m_irq <= 1;
    end else begin
      bit trip, nf;
      trip = oc && (m_cnt == LIM - 1);
      nf = (trip && !m_ocp) || (ot && !m_tsd) || (uv && !m_uv);
      m_cnt <= !oc ? 0 : (m_cnt == LIM - 1 ? m_cnt : m_cnt + 1);
      if (trip) m_ocp <= 1; else if (cap && !oc) m_ocp <= 0;
      if (ot)   m_tsd <= 1; else if (cap && !ot) m_tsd <= 0;
      if (uv)   m_uv  <= 1; else if (cap && !uv) m_uv  <= 0;
      if (nf) m_irq <= 1; else if (rd) m_irq <= 0;
    end
  end

  function automatic bit exp_en();
    return en && !m_ocp && !m_tsd && !m_uv && !ot && !uv;
  endfunction

  function automatic logic [7:0] exp_st();
    logic [7:0] s = 8'h00;
    s[0] = !exp_en();
    s[2] = m_ocp;
    s[4] = !exp_en() || vw;
    s[6] = m_tsd;
    s[7] = m_uv;
    return s;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 R6 R7 R8: reset state, output off, interrupt pending
    chk("R1 reset status", st, 8'h11);
    chk("R8 irq at reset", {7'd0, irq_n}, 8'h00);
    chk("R10 off at reset", {7'd0, oen}, 8'h00);

    en = 1; rd = 1; tick(); rd = 0;
    chk("R9 release", {7'd0, irq_n}, 8'h01);
    chk("R6 DIS clear when on", st, 8'h00);
    chk("R10 enabled", {7'd0, oen}, 8'h01);

    vw = 1; tick();
    chk("R7 PNG window", st, 8'h10);
    chk("R8 PNG no irq", {7'd0, irq_n}, 8'h01);
    vw = 0; en = 0; tick();
    chk("R6 DIS commanded off", st, 8'h11);
    chk("R8 DIS no irq", {7'd0, irq_n}, 8'h01);
    en = 1; tick();

    // R2 persistence boundary
    oc = 1; tick(LIM - 1);
    chk("R2 not yet", {7'd0, st[2]}, 8'h00);
    tick();
    chk("R2 OCP set", st, 8'h15);
    chk("R8 irq on OCP", {7'd0, irq_n}, 8'h00);
    cap = 1; tick(); cap = 0;
    chk("R4 OCP held while live", {7'd0, st[2]}, 8'h01);
    oc = 0; tick();
    chk("R10 stays off until read", {7'd0, oen}, 8'h00);
    rd = 1; cap = 1; tick(); rd = 0; cap = 0;
    chk("R4 OCP cleared", st, 8'h00);
    chk("R9 irq released", {7'd0, irq_n}, 8'h01);
    chk("R10 re-enabled", {7'd0, oen}, 8'h01);

    // R3 restart on dropout
    oc = 1; tick(LIM - 1); oc = 0; tick(); oc = 1; tick(LIM - 1);
    chk("R3 restarted", {7'd0, st[2]}, 8'h00);
    oc = 0; tick();

    // R5 thermal
    ot = 1; #1;
    chk("R5 same cycle cut", {7'd0, oen}, 8'h00);
    tick();
    chk("R5 TSD latched", st, 8'h51);
    chk("R8 irq on TSD", {7'd0, irq_n}, 8'h00);
    cap = 1; rd = 1; tick(); cap = 0; rd = 0;
    chk("R4 TSD held live", {7'd0, st[6]}, 8'h01);
    chk("R9 release while live", {7'd0, irq_n}, 8'h01);
    ot = 0; tick();
    chk("R4 TSD no read no clear", {7'd0, st[6]}, 8'h01);
    cap = 1; tick(); cap = 0;
    chk("R4 TSD cleared", st, 8'h00);

    uv = 1; tick(); uv = 0; tick();
    chk("R5 UVLO latched", st, 8'h91);
    chk("R8 irq on UVLO", {7'd0, irq_n}, 8'h00);
    cap = 1; rd = 1; tick(); cap = 0; rd = 0;
    chk("R4 UVLO cleared", st, 8'h00);

    // random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) oc = ~oc;
      if ($urandom_range(39) == 0) ot = ~ot;
      if ($urandom_range(49) == 0) uv = ~uv;
      if ($urandom_range(7) == 0)  vw = ~vw;
      if ($urandom_range(19) == 0) en = ~en;
      rd  = ($urandom_range(5) == 0);
      cap = ($urandom_range(5) == 0);
      tick();
      chk("R1 R2 R4 status rand", st, exp_st());
      chk("R8 R9 irq rand", {7'd0, irq_n}, {7'd0, !m_irq});
      chk("R10 R5 enable rand", {7'd0, oen}, {7'd0, exp_en()});
    end
    finish_run();
  end
endmodule